// File: doc/BRIEF.md
# On-Chip RAM Enable Decoder

This block sits on a CPU's 16-bit address bus and decides, cycle by cycle, where an access lands. It holds an 8-bit system control register. Bit 0 of that register is the RAM enable. Together with the operating mode, the enable decides whether accesses inside a fixed address window reach an internal RAM, go out on the external data bus, or are answered with a dummy value.

The internal RAM is a small synchronous byte array that covers the window exactly. A parameter picks one of two window sizes:

- Large variant: 0xF780..0xFF7F, 2048 bytes.
- Small variant: 0xFB80..0xFF7F, 1024 bytes.

The control register sits at one fixed address, 0xFFC4 by default, which lies outside the window.

Every internal read answers one clock after the access. This covers RAM reads, register reads and the dummy 0xFF response. A standby input stops the block from acting on the bus. The register, including its enable bit, holds its value through standby, and only reset reinitialises it.

Top module: `ram_window_router`

## Requirements
- R1: Reset clears `rdata` to 0xFF and returns the control register to 0x09: bit 3 (read-only flag) is 1, bit 0 (RAM enable) is 1, and all other bits are 0. This holds even if the enable was 0 before reset.
- R2: A write to `CTRL_ADDR` loads `wdata` into the control register at the next clock edge. Bit 3 ignores the write and keeps its value.
- R3: With the enable at 1, any access to an address in the window (default 0xF780..0xFF7F) asserts `ram_sel`. Writes store the byte and reads return it.
- R4: In expanded modes (`mode` not equal to 2'd3) with the enable at 0, a window access asserts `ext_sel` and not `ram_sel`.
- R5: In single-chip mode (`mode` = 2'd3) with the enable at 0, a window access asserts neither select. A write has no effect on the RAM, and a read returns 0xFF.
- R6: Addresses outside the window never assert `ram_sel`. In expanded modes they assert `ext_sel`, except the register address. In single-chip mode they assert neither select.
- R7: Read data appears on `rdata` one cycle after the read. This applies to the RAM, the register and the dummy 0xFF. In a cycle with no internal read, the next `rdata` is 0xFF.
- R8: Changing the enable leaves the RAM contents alone. Clearing and then setting it makes earlier data readable again.
- R9: While `standby` is 1, no access asserts a select or changes the register or RAM, and `rdata` becomes 0xFF. The register, including the enable, keeps its value across standby.
- R10: `ram_sel` and `ext_sel` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Software standby indication; accesses are ignored |
| mode | input | 2 | Operating mode; 2'd3 is single-chip, other values are expanded |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| ram_sel | output | 1 | Access is routed to the internal RAM |
| ext_sel | output | 1 | Access is routed to the external data bus |
| rdata | output | 8 | Read data, one cycle after the read |

## Verification
Two functions can meet in one cycle: a register write that changes the enable, and the routing decision for the next window access. The bench provokes this by writing the enable and then accessing the window on the very next cycle, in both expanded and single-chip modes. The routing must already follow the new bit. A second meeting point is a standby cycle that carries a register write. It is judged by reading the register back after standby ends and comparing the value with a behavioural model that drops the write.

// File: rtl/ram_window_router.sv
module ram_window_router #(
  parameter bit          LARGE_RAM = 1'b1,
  parameter logic [15:0] CTRL_ADDR = 16'hFFC4,
  parameter logic [7:0]  CTRL_INIT = 8'h09,
  parameter logic [7:0]  RO_MASK   = 8'h08
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standby,
  input  logic [1:0]  mode,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        rd,
  input  logic        wr,
  output logic        ram_sel,
  output logic        ext_sel,
  output logic [7:0]  rdata
);
  localparam logic [15:0] WIN_LO = LARGE_RAM ? 16'hF780 : 16'hFB80;
  localparam logic [15:0] WIN_HI = 16'hFF7F;
  localparam int          DEPTH  = int'(WIN_HI) - int'(WIN_LO) + 1;
  localparam int          IW     = $clog2(DEPTH);

  logic [7:0]    ctrl_q;
  logic [7:0]    mem [DEPTH];
  logic          access, in_win, hit_reg, single_chip;
  logic [15:0]   offset;
  logic [IW-1:0] idx;

  assign access      = (rd | wr) & ~standby;
  assign in_win      = (addr >= WIN_LO) && (addr <= WIN_HI);
  assign hit_reg     = (addr == CTRL_ADDR);
  assign single_chip = (mode == 2'd3);
  assign offset      = addr - WIN_LO;
  assign idx         = offset[IW-1:0];

  assign ram_sel = access & in_win & ctrl_q[0];
  assign ext_sel = access & ~single_chip & ~hit_reg & ~ram_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl_q <= CTRL_INIT;
    else if (access && wr && hit_reg)
      ctrl_q <= (wdata & ~RO_MASK) | (ctrl_q & RO_MASK);
  end

  always_ff @(posedge clk) begin
    if (ram_sel && wr)
      mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata <= 8'hFF;
    else if (access && rd && hit_reg)
      rdata <= ctrl_q;
    else if (ram_sel && rd)
      rdata <= mem[idx];
    else
      rdata <= 8'hFF;
  end
endmodule

module ram_window_router_chk #(
  parameter bit          LARGE_RAM = 1'b1,
  parameter logic [15:0] CTRL_ADDR = 16'hFFC4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        standby,
  input logic [1:0]  mode,
  input logic [15:0] addr,
  input logic [7:0]  wdata,
  input logic        rd,
  input logic        wr,
  input logic        ram_sel,
  input logic        ext_sel,
  input logic [7:0]  rdata,
  input logic [7:0]  ctrl_q
);
  logic [15:0] lo;
  logic        win;
  assign lo  = LARGE_RAM ? 16'hF780 : 16'hFB80;
  assign win = (addr >= lo) && (addr <= 16'hFF7F);

  a_r10_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_sel && ext_sel));

  a_r6_outside_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> !ram_sel);

  a_r5_single_chip_dummy: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && !standby && win && mode == 2'd3 && !ctrl_q[0]) |=> rdata == 8'hFF);

  a_r5_single_chip_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (win && mode == 2'd3 && !ctrl_q[0]) |-> (!ram_sel && !ext_sel));

  a_r9_standby_hold: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> $stable(ctrl_q));

  a_r9_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!ram_sel && !ext_sel));

  a_r2_ro_bit_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !standby && addr == CTRL_ADDR) |=> ctrl_q[3] == $past(ctrl_q[3]));

  a_r4_expanded_ext: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd || wr) && !standby && win && mode != 2'd3 && !ctrl_q[0]) |-> ext_sel);
endmodule

bind ram_window_router ram_window_router_chk #(.LARGE_RAM(LARGE_RAM), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .mode(mode), .addr(addr),
  .wdata(wdata), .rd(rd), .wr(wr), .ram_sel(ram_sel), .ext_sel(ext_sel),
  .rdata(rdata), .ctrl_q(ctrl_q));

// File: tb/ram_window_router_bench.sv
module ram_window_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic [1:0]  mode = 2'd3;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  wdata = 8'h00;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic        ram_sel, ext_sel;
  logic [7:0]  rdata;

  int tests = 0;
  int fails = 0;

  logic [7:0] m_ctrl;
  logic [7:0] m_mem [int];

  always #5 clk = ~clk;

  ram_window_router u_ram_window_router (
    .clk(clk), .rst_n(rst_n), .standby(standby), .mode(mode), .addr(addr),
    .wdata(wdata), .rd(rd), .wr(wr), .ram_sel(ram_sel), .ext_sel(ext_sel),
    .rdata(rdata));

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [1:0] md, input logic sb,
                      input logic r, input logic w, input logic [15:0] a, input logic [7:0] d);
    bit acc, win, isreg, e_ram, e_ext;
    logic [7:0] e_rd;
    @(negedge clk);
    mode = md; standby = sb; rd = r; wr = w; addr = a; wdata = d;
    acc   = (r || w) && !sb;
    win   = (a >= 16'hF780) && (a <= 16'hFF7F);
    isreg = (a == 16'hFFC4);
    e_ram = acc && win && m_ctrl[0];
    e_ext = acc && (md != 2'd3) && !isreg && !e_ram;
    e_rd  = 8'hFF;
    if (r && !sb) begin
      if (isreg) e_rd = m_ctrl;
      else if (e_ram) e_rd = m_mem.exists(int'(a)) ? m_mem[int'(a)] : 8'hFF;
    end
    if (w && !sb) begin
      if (isreg) m_ctrl = (d & 8'hF7) | (m_ctrl & 8'h08);
      else if (e_ram) m_mem[int'(a)] = d;
    end
    #1;
    check(tag, "ram_sel", int'(ram_sel), int'(e_ram));
    check(tag, "ext_sel", int'(ext_sel), int'(e_ext));
    check("R10", "exclusive selects", int'(ram_sel && ext_sel), 0);
    @(posedge clk); #1;
    check(tag, "rdata", int'(rdata), int'(e_rd));
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; rd = 1'b0; wr = 1'b0; standby = 1'b0;
    m_ctrl = 8'h09;
    #2;
    check("R1", "rdata after reset", int'(rdata), 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_ctrl = 8'h09;
    repeat (2) @(posedge clk);
    do_reset();
    step("R1", 2'd3, 0, 1, 0, 16'hFFC4, 8'h00);
    step("R7", 2'd3, 0, 0, 0, 16'h0000, 8'h00);
    // R3 window edges, large variant
    step("R3", 2'd3, 0, 0, 1, 16'hF780, 8'hA5);
    step("R3", 2'd3, 0, 0, 1, 16'hFF7F, 8'h5A);
    step("R3", 2'd1, 0, 0, 1, 16'hFB80, 8'h3C);
    step("R3", 2'd3, 0, 1, 0, 16'hF780, 8'h00);
    step("R3", 2'd3, 0, 1, 0, 16'hFF7F, 8'h00);
    step("R7", 2'd2, 0, 1, 0, 16'hFB80, 8'h00);
    // R6 outside the window
    step("R6", 2'd3, 0, 0, 1, 16'hF77F, 8'h77);
    step("R6", 2'd3, 0, 1, 0, 16'hFF80, 8'h00);
    step("R6", 2'd1, 0, 1, 0, 16'hF77F, 8'h00);
    step("R6", 2'd2, 0, 0, 1, 16'h0100, 8'h12);
    step("R6", 2'd1, 0, 1, 0, 16'hFFC4, 8'h00);
    // R2 register writes, read-only bit 3
    step("R2", 2'd3, 0, 0, 1, 16'hFFC4, 8'hFF);
    step("R2", 2'd3, 0, 1, 0, 16'hFFC4, 8'h00);
    step("R2", 2'd3, 0, 0, 1, 16'hFFC4, 8'h00);
    // R4 expanded with enable cleared, on the very next cycle
    step("R4", 2'd1, 0, 1, 0, 16'hF780, 8'h00);
    step("R4", 2'd2, 0, 0, 1, 16'hFF7F, 8'h99);
    step("R2", 2'd1, 0, 1, 0, 16'hFFC4, 8'h00);
    // R5 single-chip with enable cleared
    step("R5", 2'd3, 0, 0, 1, 16'hF780, 8'h11);
    step("R5", 2'd3, 0, 1, 0, 16'hF780, 8'h00);
    step("R5", 2'd3, 0, 1, 0, 16'hFF7F, 8'h00);
    // R8 re-enable, earlier data is back and the dropped writes left no trace
    step("R8", 2'd3, 0, 0, 1, 16'hFFC4, 8'h01);
    step("R8", 2'd3, 0, 1, 0, 16'hF780, 8'h00);
    step("R8", 2'd3, 0, 1, 0, 16'hFF7F, 8'h00);
    step("R8", 2'd1, 0, 1, 0, 16'hFB80, 8'h00);
    // R9 standby ignores accesses and keeps the register
    step("R9", 2'd1, 1, 0, 1, 16'hFFC4, 8'h00);
    step("R9", 2'd3, 1, 0, 1, 16'hF780, 8'hEE);
    step("R9", 2'd1, 1, 1, 0, 16'hF780, 8'h00);
    step("R9", 2'd3, 0, 1, 0, 16'hFFC4, 8'h00);
    step("R9", 2'd3, 0, 1, 0, 16'hF780, 8'h00);
    step("R9", 2'd3, 0, 0, 1, 16'hFFC4, 8'h40);
    step("R9", 2'd3, 1, 0, 0, 16'h0000, 8'h00);
    step("R9", 2'd3, 1, 1, 0, 16'hFFC4, 8'h00);
    step("R9", 2'd3, 0, 1, 0, 16'hFFC4, 8'h00);
    step("R9", 2'd2, 0, 1, 0, 16'hF780, 8'h00);
    // R1 reset forces the enable back to 1
    do_reset();
    step("R1", 2'd3, 0, 1, 0, 16'hFFC4, 8'h00);
    step("R1", 2'd3, 0, 1, 0, 16'hF780, 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule